// File: doc/BRIEF.md
# Banked Memory Mapping Unit

This block sits between a CPU with a 16-bit address bus and a physical memory of up to 128 blocks of 16 KB each, 2 MB in total. It produces a 21-bit physical address. The top two CPU address bits pick one of four windows. Each window has an 8-bit mapping register, and the register chooses the physical block that the low 14 address bits land in.

A window can be mapped in one of two ways. It can point into the eight standard blocks, with one block for reads and a different block for writes. Or it can point at a single expansion block that serves both reads and writes.

A shared control register can force any window to read from its write block, so software can switch between split and unified access with one I/O write. When the selected expansion block is beyond the installed memory, the unit folds it onto an internal block, using as many low bits of the number as the internal memory size allows.

Software loads the registers through I/O writes. Two configuration inputs describe the system: the number of contiguous blocks present, and the internal memory size. The physical address and the access strobes go to a separate DRAM controller.

Top module: `bank_map_unit`

## Requirements
- R1: `mem_addr` equals {block, `cpu_addr[13:0]`}. The window is selected by `cpu_addr[15:14]`. The block is the window's write block when `cpu_wr` is 1 and its read block otherwise.
- R2: An I/O write to port F0h, F1h, F2h or F3h loads the mapping register of window 0, 1, 2 or 3, and the new mapping takes effect from the next clock cycle. I/O writes to any other port leave all mappings unchanged.
- R3: With mapping bit 7 clear, bits 6:4 give the standard read block and bits 2:0 give the standard write block. Bit 3 has no effect.
- R4: With mapping bit 7 set, bits 6:0 give one expansion block number, used for both reads and writes. Numbers 0 to 7 reach the matching standard block.
- R5: An I/O write to port F4h sets the force bits. Data bit 7 controls window 3, bit 6 window 0, bit 5 window 2 and bit 4 window 1. When a window's bit is set, its read access uses its write block. Data bits 3:0 have no effect.
- R6: A force bit has no effect on a window that is mapped to an expansion block.
- R7: An expansion number greater than or equal to `blocks_present` is replaced by its low 3 bits when `mem_size` is 0 (128 KB), its low 4 bits when `mem_size` is 1 (256 KB), and its low 5 bits when `mem_size` is 2 or 3 (512 KB). Numbers below `blocks_present` pass through unchanged.
- R8: After reset, all mapping registers and force bits are zero, so every window reads from and writes to standard block 0.
- R9: `mem_rd` and `mem_wr` follow `cpu_rd` and `cpu_wr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port number |
| io_data | input | 8 | I/O write data |
| blocks_present | input | 8 | Number of contiguous blocks fitted (8 to 128) |
| mem_size | input | 2 | Internal memory size: 0 = 128 KB, 1 = 256 KB, 2 or 3 = 512 KB |
| mem_addr | output | 21 | Physical address |
| mem_rd | output | 1 | Read strobe to memory |
| mem_wr | output | 1 | Write strobe to memory |

## Verification
Directed patterns cover the following cases:
- a standard mapping with distinct read and write blocks and bit 3 set, which separates the read path from the write path;
- each force bit applied in turn, which shows that the scrambled bit-to-window order is honoured and that the other windows are left alone;
- an expansion number at `blocks_present` minus one and one at `blocks_present`, which locates the fold boundary exactly;
- the same out-of-range number under each `mem_size` code, which tells the 3-, 4- and 5-bit folds apart.

Random interleavings of register writes (including writes to neighbouring ports that must be ignored), configuration changes and accesses in all four windows are then compared against a bench model.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
    localparam int NUM_WIN   = 4;
    localparam int WIN_W     = $clog2(NUM_WIN);
    localparam int OFS_W     = 14;
    localparam int CPU_W     = WIN_W + OFS_W;
    localparam int BLK_W     = 7;
    localparam int PA_W      = BLK_W + OFS_W;
    localparam int MAP_W     = 8;
    localparam int STD_W     = 3;
    localparam int EXT_FLAG  = 7;
    localparam int RD_LSB    = 4;
    localparam int WR_LSB    = 0;
    localparam int MIN_FOLD  = 3;
    localparam int MAX_FOLD  = 5;

    typedef struct packed {
        logic [NUM_WIN-1:0][MAP_W-1:0] map;
        logic [NUM_WIN-1:0]            force_rw;
    } bmu_state_t;

    // data bit of the control port that drives the force bit of window w
    function automatic int force_pos(input int w);
        case (w)
            0:       return 6;
            1:       return 4;
            2:       return 5;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/bmu_regs.sv
module bmu_regs
    import bmu_pkg::*;
#(
    parameter logic [7:0] MAP_BASE = 8'hF0,
    parameter logic [7:0] CTL_PORT = 8'hF4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic [7:0]       io_port,
    input  logic [7:0]       io_data,
    output bmu_state_t       state_q
);
    bmu_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (io_wr) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (io_port == MAP_BASE + 8'(w))
                    state_d.map[w] = io_data;
                if (io_port == CTL_PORT)
                    state_d.force_rw[w] = io_data[force_pos(w)];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/bmu_win_select.sv
module bmu_win_select
    import bmu_pkg::*;
(
    input  logic [MAP_W-1:0] map_byte,
    input  logic             force_rw,
    input  logic             is_wr,
    input  logic [BLK_W:0]   blocks_present,
    input  logic [1:0]       mem_size,
    output logic [BLK_W-1:0] blk
);
    logic [BLK_W-1:0] ext_num;
    logic [BLK_W-1:0] fold_mask;
    logic [BLK_W-1:0] ext_eff;
    logic [STD_W-1:0] std_rd;
    logic [STD_W-1:0] std_wr;
    logic [STD_W-1:0] std_sel;
    int               fold_bits;

    always_comb begin
        ext_num   = map_byte[BLK_W-1:0];
        fold_bits = MIN_FOLD + int'(mem_size);
        if (fold_bits > MAX_FOLD)
            fold_bits = MAX_FOLD;
        fold_mask = BLK_W'((1 << fold_bits) - 1);
        ext_eff   = ({1'b0, ext_num} >= blocks_present) ? (ext_num & fold_mask) : ext_num;

        std_wr  = map_byte[WR_LSB +: STD_W];
        std_rd  = force_rw ? std_wr : map_byte[RD_LSB +: STD_W];
        std_sel = is_wr ? std_wr : std_rd;

        blk = map_byte[EXT_FLAG] ? ext_eff : {{(BLK_W-STD_W){1'b0}}, std_sel};
    end
endmodule

// File: rtl/bank_map_unit.sv
module bank_map_unit
    import bmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CPU_W-1:0] cpu_addr,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic             io_wr,
    input  logic [7:0]       io_port,
    input  logic [7:0]       io_data,
    input  logic [BLK_W:0]   blocks_present,
    input  logic [1:0]       mem_size,
    output logic [PA_W-1:0]  mem_addr,
    output logic             mem_rd,
    output logic             mem_wr
);
    bmu_state_t                    state_q;
    logic [NUM_WIN-1:0][BLK_W-1:0] win_blk;
    logic [WIN_W-1:0]              win_idx;

    bmu_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_port (io_port),
        .io_data (io_data),
        .state_q (state_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        bmu_win_select u_sel (
            .map_byte       (state_q.map[w]),
            .force_rw       (state_q.force_rw[w]),
            .is_wr          (cpu_wr),
            .blocks_present (blocks_present),
            .mem_size       (mem_size),
            .blk            (win_blk[w])
        );
    end

    assign win_idx  = cpu_addr[CPU_W-1:OFS_W];
    assign mem_addr = {win_blk[win_idx], cpu_addr[OFS_W-1:0]};
    assign mem_rd   = cpu_rd;
    assign mem_wr   = cpu_wr;
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker
    import bmu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CPU_W-1:0] cpu_addr,
    input logic             cpu_rd,
    input logic             cpu_wr,
    input logic             io_wr,
    input logic [BLK_W:0]   blocks_present,
    input logic [1:0]       mem_size,
    input logic [PA_W-1:0]  mem_addr,
    input logic             mem_rd,
    input logic             mem_wr,
    input bmu_state_t       state_q
);
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]); // R1

    AST_STROBE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd == cpu_rd) && (mem_wr == cpu_wr)); // R9

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (state_q == '0)); // R8

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(io_wr) |-> $stable(state_q)); // R2

    AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd || cpu_wr) && (mem_size == 2'd0) && (blocks_present >= 8'd8)
        |-> ({1'b0, mem_addr[PA_W-1:OFS_W]} < blocks_present)); // R7
endmodule

bind bank_map_unit bmu_checker u_chk (.*);

// File: tb/sim_bank_map_unit.sv
module sim_bank_map_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_port = '0;
    logic [7:0]  io_data = '0;
    logic [7:0]  blocks_present = 8'd32;
    logic [1:0]  mem_size = 2'd2;
    logic [20:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] m_map [4];
    logic [3:0] m_force;

    bank_map_unit u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
        .blocks_present(blocks_present), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ctl_bit(input int w);
        if (w == 0) return 6;
        if (w == 1) return 4;
        if (w == 2) return 5;
        return 7;
    endfunction

    function automatic logic [6:0] exp_blk(input int w, input logic wr);
        logic [7:0] m;
        logic [6:0] e;
        logic [6:0] mask;
        m = m_map[w];
        if (m[7]) begin
            e = m[6:0];
            mask = (mem_size == 2'd0) ? 7'h07 : (mem_size == 2'd1) ? 7'h0F : 7'h1F;
            if ({1'b0, e} >= blocks_present) e = e & mask;
            return e;
        end
        if (wr || m_force[w]) return {4'b0, m[2:0]};
        return {4'b0, m[6:4]};
    endfunction

    task automatic io_write(input logic [7:0] port, input logic [7:0] data);
        @(negedge clk);
        io_wr = 1'b1; io_port = port; io_data = data;
        @(posedge clk); #1;
        if (port >= 8'hF0 && port <= 8'hF3) m_map[port - 8'hF0] = data;
        if (port == 8'hF4)
            for (int w = 0; w < 4; w++) m_force[w] = data[ctl_bit(w)];
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic access(input logic [15:0] a, input logic rd, input logic wr, input string req);
        logic [20:0] exp;
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
        #2;
        exp = {exp_blk(int'(a[15:14]), wr), a[13:0]};
        total++;
        if (mem_addr !== exp || mem_rd !== rd || mem_wr !== wr) begin
            bad++;
            $display("FAIL %s: addr=%h rd=%b wr=%b got addr=%h rd=%b wr=%b expected addr=%h",
                     req, a, rd, wr, mem_addr, mem_rd, mem_wr, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        void'($urandom(32'd1234));
        for (int w = 0; w < 4; w++) m_map[w] = 8'h00;
        m_force = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R8: reset map, every window standard block 0
        for (int w = 0; w < 4; w++) begin
            access({2'(w), 14'h1A5}, 1'b1, 1'b0, "R8");
            access({2'(w), 14'h3FF}, 1'b0, 1'b1, "R8");
        end

        // R3: split blocks, bit 3 ignored
        io_write(8'hF1, 8'b0101_1011);
        access(16'h4123, 1'b1, 1'b0, "R3");
        access(16'h4123, 1'b0, 1'b1, "R3");
        // R1: idle cycle still drives the read block
        access(16'h7FFF, 1'b0, 1'b0, "R1");

        // R5: force bits in scrambled order
        io_write(8'hF0, 8'b0010_0111);
        io_write(8'hF4, 8'h10);
        access(16'h4000, 1'b1, 1'b0, "R5");
        access(16'h0000, 1'b1, 1'b0, "R5");
        io_write(8'hF4, 8'h40);
        access(16'h0001, 1'b1, 1'b0, "R5");
        access(16'h4001, 1'b1, 1'b0, "R5");
        io_write(8'hF4, 8'h0F);
        access(16'h0002, 1'b1, 1'b0, "R5");
        access(16'h4002, 1'b1, 1'b0, "R5");

        // R2: other ports ignored
        io_write(8'hF5, 8'hFF);
        io_write(8'hEF, 8'hFF);
        io_write(8'hF8, 8'hC3);
        for (int w = 0; w < 4; w++) access({2'(w), 14'h0055}, 1'b1, 1'b0, "R2");

        // R4: expansion, shared read/write, low numbers
        blocks_present = 8'd32; mem_size = 2'd2;
        io_write(8'hF2, 8'h85);
        access(16'h8010, 1'b1, 1'b0, "R4");
        access(16'h8010, 1'b0, 1'b1, "R4");
        io_write(8'hF2, 8'h94);
        access(16'hBFFF, 1'b1, 1'b0, "R4");

        // R7: fold boundary and sizes
        io_write(8'hF3, 8'h9F);
        access(16'hC000, 1'b1, 1'b0, "R7");
        io_write(8'hF3, 8'hA0);
        access(16'hC000, 1'b1, 1'b0, "R7");
        io_write(8'hF3, 8'hDB);
        for (int s = 0; s < 4; s++) begin
            mem_size = 2'(s);
            blocks_present = (s == 0) ? 8'd8 : (s == 1) ? 8'd16 : 8'd32;
            access(16'hC100, 1'b0, 1'b1, "R7");
        end
        blocks_present = 8'd128;
        access(16'hC100, 1'b1, 1'b0, "R7");

        // R6: force on an expansion window
        io_write(8'hF4, 8'h80);
        access(16'hC200, 1'b1, 1'b0, "R6");

        // mixed random
        for (int i = 0; i < 600; i++) begin
            int c;
            c = int'($urandom_range(0, 9));
            if (c < 3) begin
                io_write(8'hF0 + 8'($urandom_range(0, 5)), 8'($urandom));
            end else if (c == 3) begin
                mem_size = 2'($urandom_range(0, 3));
                blocks_present = 8'($urandom_range(8, 128));
            end else begin
                a = 16'($urandom);
                if ($urandom_range(0, 1) == 0) access(a, 1'b1, 1'b0, "R1");
                else access(a, 1'b0, 1'b1, "R9");
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule